// File: doc/BRIEF.md
# Dependency-Checking Issue Window Scheduler

The block is a small out-of-order instruction window. Up to three decoded micro-ops enter it in one clock. Each micro-op names an optional destination tag and up to two optional source tags. A tag stands for one architectural resource, which may be a register or a flag. Each micro-op also carries the class of execution port it needs. On entry, every micro-op is turned into a pair of one-hot resource sets, one for what it reads and one for what it writes. The window compares these sets against every older entry that is still in flight. From this it finds which entries have a read-after-write dependency that is not yet resolved.

In each cycle the window grants at most one entry per port class. The grant goes to the oldest entry of that class that is free of dependencies. Execution units report finished work with completion pulses that carry the entry index. Finished entries then leave the window in the order they arrived, up to three per cycle. If the window cannot take a full group of three, a ready output goes low and the whole incoming group is held back.

Top module: `iw_sched`

## Requirements
- R1: Accepts up to three micro-ops per cycle while `in_ready` is high. Valid slots take consecutive entry indices starting at the current tail, lower slot index first, so slot 0 is the oldest of its group. `in_id[s]` reports the index given to slot `s`, which is the tail plus the number of valid slots below `s`.
- R2: `in_ready` is high exactly when at least three entries are free. While it is low, the whole incoming group is ignored and no entry is created for any of its slots.
- R3: An entry whose source tag equals the destination tag of an older entry that has not completed is not issued. It becomes eligible in the cycle after the edge that records that older entry's completion. There is no same-cycle wakeup.
- R4: For every port class, the block issues the oldest eligible entry of that class. It issues at most one entry per port per cycle, and it issues each entry only once.
- R5: An entry with no unresolved dependency can issue in the first cycle after the edge that allocated it.
- R6: A completion pulse marks its entry finished only when that entry is valid and was issued before that edge. A pulse for an entry that is not yet issued, or that is not in the window, has no effect.
- R7: Finished entries retire in allocation order, up to three per cycle. Retirement takes a run of consecutive finished entries that starts at the oldest entry and stops at the first unfinished one. A retirement shows in the cycle after the completion edge.
- R8: After reset the window is empty, `in_ready` is high, and no issue or retirement is signalled.
- R9: Write-after-read and write-after-write overlaps do not delay issue. Only a read that overlaps an older write creates a dependency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | SLOTS | Valid flag per incoming slot |
| in_dst | input | SLOTS x TW | Destination tag per slot |
| in_dst_en | input | SLOTS | Destination tag used |
| in_src_a | input | SLOTS x TW | First source tag |
| in_src_a_en | input | SLOTS | First source used |
| in_src_b | input | SLOTS x TW | Second source tag |
| in_src_b_en | input | SLOTS | Second source used |
| in_port | input | SLOTS x PW | Execution port class |
| in_ready | output | 1 | Room for a full group |
| in_id | output | SLOTS x IW | Entry index given to each slot |
| iss_valid | output | NPORT | Issue grant per port |
| iss_id | output | NPORT x IW | Entry issued on each port |
| cmp_valid | input | NPORT | Completion pulse per port |
| cmp_id | input | NPORT x IW | Entry finishing on each port |
| ret_valid | output | RET | Retirement per lane, lane 0 oldest |
| ret_id | output | RET x IW | Entry retiring on each lane |

## Verification
A directed group of three checks several behaviours together. It has a read-after-write pair, a write-after-write pair on another port and a completion aimed at an entry that has not issued. Together these separate a correct dependency rule from one that also stalls on destination overlap or that accepts early completions. The same sequence also distinguishes in-order retirement from out-of-order retirement, and single-lane retirement from multi-lane retirement.

A long pseudo-random sweep follows. It draws tags from a small pool of resources so that dependency chains are dense. It switches between phases where completions flow and phases where they are held back. The held-back phases fill the window and exercise the all-or-nothing stall. Every cycle a queue model in the bench predicts the exact grant per port, each retirement lane and each allocated index. Any error in age order, wakeup timing or pointer wrap therefore shows up as a mismatch.

// File: rtl/iw_pkg.sv
package iw_pkg;

   localparam int unsigned GROUP_MAX = 3;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/iw_alloc.sv
module iw_alloc #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned SLOTS = 3,
   localparam int unsigned IW    = $clog2(DEPTH),
   localparam int unsigned CW    = $clog2(SLOTS + 1)
) (
   input  logic [IW-1:0]            tail,
   input  logic [SLOTS-1:0]         req,
   input  logic                     accept,
   output logic [SLOTS-1:0][IW-1:0] slot_id,
   output logic [SLOTS-1:0]         slot_we,
   output logic [CW-1:0]            n_alloc
);

   logic [CW-1:0] run;

   // Valid slots are packed onto consecutive indices from the tail.
   always_comb begin
      run = '0;
      for (int s = 0; s < SLOTS; s++) begin
         slot_id[s] = tail + IW'(run);
         slot_we[s] = accept & req[s];
         run        = run + CW'(req[s]);
      end
      n_alloc = accept ? run : '0;
   end

endmodule

// File: rtl/iw_depmatrix.sv
module iw_depmatrix #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned NRES  = 16,
   localparam int unsigned IW    = $clog2(DEPTH)
) (
   input  logic [IW-1:0]                  head,
   input  logic [DEPTH-1:0]               valid,
   input  logic [DEPTH-1:0]               done,
   input  logic [DEPTH-1:0][NRES-1:0]     rd_set,
   input  logic [DEPTH-1:0][NRES-1:0]     wr_set,
   output logic [DEPTH-1:0]               clear
);

   logic [DEPTH-1:0][IW-1:0]    age;
   logic [DEPTH-1:0][DEPTH-1:0] hold;

   for (genvar o = 0; o < DEPTH; o++) begin : g_age
      assign age[o] = IW'(o) - head;
   end

   // hold[e][o]: entry o is older, unfinished and writes something e reads.
   for (genvar e = 0; e < DEPTH; e++) begin : g_row
      for (genvar o = 0; o < DEPTH; o++) begin : g_col
         if (e == o) begin : g_self
            assign hold[e][o] = 1'b0;
         end else begin : g_pair
            assign hold[e][o] = valid[o] & ~done[o] & (age[o] < age[e])
                              & (|(rd_set[e] & wr_set[o]));
         end
      end
      assign clear[e] = ~|hold[e];
   end

endmodule

// File: rtl/iw_select.sv
module iw_select #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned NPORT = 2,
   localparam int unsigned IW    = $clog2(DEPTH),
   localparam int unsigned PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic [IW-1:0]             head,
   input  logic [DEPTH-1:0]          cand,
   input  logic [DEPTH-1:0][PW-1:0]  port_of,
   output logic [NPORT-1:0]          gnt,
   output logic [NPORT-1:0][IW-1:0]  gnt_id
);

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      logic          g;
      logic [IW-1:0] gid;

      // Scan youngest to oldest so that the oldest match is kept.
      always_comb begin
         logic [IW-1:0] idx;
         g   = 1'b0;
         gid = '0;
         for (int k = DEPTH - 1; k >= 0; k--) begin
            idx = head + IW'(k);
            if (cand[idx] && (port_of[idx] == PW'(p))) begin
               g   = 1'b1;
               gid = idx;
            end
         end
      end

      assign gnt[p]    = g;
      assign gnt_id[p] = gid;
   end

endmodule

// File: rtl/iw_retire.sv
module iw_retire #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned RET   = 3,
   localparam int unsigned IW    = $clog2(DEPTH),
   localparam int unsigned RW    = $clog2(RET + 1)
) (
   input  logic [IW-1:0]           head,
   input  logic [DEPTH-1:0]        valid,
   input  logic [DEPTH-1:0]        done,
   output logic [RET-1:0]          rv,
   output logic [RET-1:0][IW-1:0]  rid,
   output logic [RW-1:0]           n_ret
);

   always_comb begin
      logic          go;
      logic [IW-1:0] idx;
      go    = 1'b1;
      n_ret = '0;
      for (int k = 0; k < RET; k++) begin
         idx    = head + IW'(k);
         rv[k]  = go & valid[idx] & done[idx];
         rid[k] = idx;
         go     = rv[k];
         n_ret  = n_ret + RW'(rv[k]);
      end
   end

endmodule

// File: rtl/iw_sched.sv
module iw_sched #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned NPORT = 2,
   parameter  int unsigned SLOTS = iw_pkg::GROUP_MAX,
   parameter  int unsigned RET   = iw_pkg::GROUP_MAX,
   parameter  int unsigned TW    = 4,
   localparam int unsigned IW    = $clog2(DEPTH),
   localparam int unsigned PW    = (NPORT > 1) ? $clog2(NPORT) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [SLOTS-1:0]          in_valid,
   input  logic [SLOTS-1:0][TW-1:0]  in_dst,
   input  logic [SLOTS-1:0]          in_dst_en,
   input  logic [SLOTS-1:0][TW-1:0]  in_src_a,
   input  logic [SLOTS-1:0]          in_src_a_en,
   input  logic [SLOTS-1:0][TW-1:0]  in_src_b,
   input  logic [SLOTS-1:0]          in_src_b_en,
   input  logic [SLOTS-1:0][PW-1:0]  in_port,
   output logic                      in_ready,
   output logic [SLOTS-1:0][IW-1:0]  in_id,
   output logic [NPORT-1:0]          iss_valid,
   output logic [NPORT-1:0][IW-1:0]  iss_id,
   input  logic [NPORT-1:0]          cmp_valid,
   input  logic [NPORT-1:0][IW-1:0]  cmp_id,
   output logic [RET-1:0]            ret_valid,
   output logic [RET-1:0][IW-1:0]    ret_id
);

   localparam int unsigned NRES = 2 ** TW;
   localparam int unsigned OW   = IW + 1;
   localparam int unsigned CW   = $clog2(SLOTS + 1);
   localparam int unsigned RW   = $clog2(RET + 1);

   // Elaboration-time parameter checks.
   if (!iw_pkg::is_pow2(DEPTH) || DEPTH < 4) begin : g_bad_depth
      $error("iw_sched: DEPTH must be a power of two of at least 4");
   end
   if (SLOTS < 1 || SLOTS > DEPTH) begin : g_bad_slots
      $error("iw_sched: SLOTS must lie in 1..DEPTH");
   end
   if (RET < 1 || RET > DEPTH) begin : g_bad_ret
      $error("iw_sched: RET must lie in 1..DEPTH");
   end
   if (NPORT < 1 || TW < 1 || TW > 8) begin : g_bad_misc
      $error("iw_sched: NPORT must be at least 1 and TW in 1..8");
   end

   // Entry state
   logic [DEPTH-1:0]            ent_valid, ent_issued, ent_done;
   logic [DEPTH-1:0][PW-1:0]    ent_port;
   logic [DEPTH-1:0][NRES-1:0]  ent_rd, ent_wr;
   logic [IW-1:0]               head, tail;
   logic [OW-1:0]               occ;

   // Incoming resource sets
   logic [SLOTS-1:0][NRES-1:0]  rd_new, wr_new;
   logic [SLOTS-1:0]            slot_we;
   logic [CW-1:0]               n_alloc;
   logic [DEPTH-1:0]            clear, cand;
   logic [RW-1:0]               n_ret;

   assign in_ready = (occ <= OW'(DEPTH - SLOTS));

   always_comb begin
      for (int s = 0; s < SLOTS; s++) begin
         rd_new[s] = '0;
         wr_new[s] = '0;
         if (in_src_a_en[s]) rd_new[s][in_src_a[s]] = 1'b1;
         if (in_src_b_en[s]) rd_new[s][in_src_b[s]] = 1'b1;
         if (in_dst_en[s])   wr_new[s][in_dst[s]]   = 1'b1;
      end
   end

   iw_alloc #(.DEPTH(DEPTH), .SLOTS(SLOTS)) u_alloc (
      .tail    (tail),
      .req     (in_valid),
      .accept  (in_ready),
      .slot_id (in_id),
      .slot_we (slot_we),
      .n_alloc (n_alloc)
   );

   iw_depmatrix #(.DEPTH(DEPTH), .NRES(NRES)) u_dep (
      .head   (head),
      .valid  (ent_valid),
      .done   (ent_done),
      .rd_set (ent_rd),
      .wr_set (ent_wr),
      .clear  (clear)
   );

   assign cand = ent_valid & ~ent_issued & clear;

   iw_select #(.DEPTH(DEPTH), .NPORT(NPORT)) u_sel (
      .head    (head),
      .cand    (cand),
      .port_of (ent_port),
      .gnt     (iss_valid),
      .gnt_id  (iss_id)
   );

   iw_retire #(.DEPTH(DEPTH), .RET(RET)) u_ret (
      .head  (head),
      .valid (ent_valid),
      .done  (ent_done),
      .rv    (ret_valid),
      .rid   (ret_id),
      .n_ret (n_ret)
   );

   // Status bits and pointers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ent_valid  <= '0;
         ent_issued <= '0;
         ent_done   <= '0;
         head       <= '0;
         tail       <= '0;
         occ        <= '0;
      end else begin
         for (int p = 0; p < NPORT; p++) begin
            if (iss_valid[p]) ent_issued[iss_id[p]] <= 1'b1;
         end
         for (int c = 0; c < NPORT; c++) begin
            if (cmp_valid[c] && ent_valid[cmp_id[c]] && ent_issued[cmp_id[c]])
               ent_done[cmp_id[c]] <= 1'b1;
         end
         for (int k = 0; k < RET; k++) begin
            if (ret_valid[k]) ent_valid[ret_id[k]] <= 1'b0;
         end
         for (int s = 0; s < SLOTS; s++) begin
            if (slot_we[s]) begin
               ent_valid[in_id[s]]  <= 1'b1;
               ent_issued[in_id[s]] <= 1'b0;
               ent_done[in_id[s]]   <= 1'b0;
            end
         end
         head <= head + IW'(n_ret);
         tail <= tail + IW'(n_alloc);
         occ  <= occ + OW'(n_alloc) - OW'(n_ret);
      end
   end

   // Payload, written only on allocation
   always_ff @(posedge clk) begin
      for (int s = 0; s < SLOTS; s++) begin
         if (slot_we[s]) begin
            ent_rd[in_id[s]]   <= rd_new[s];
            ent_wr[in_id[s]]   <= wr_new[s];
            ent_port[in_id[s]] <= in_port[s];
         end
      end
   end

endmodule

// File: rtl/iw_sched_chk.sv
module iw_sched_chk #(
   parameter  int unsigned DEPTH = 16,
   parameter  int unsigned NPORT = 2,
   parameter  int unsigned RET   = 3,
   localparam int unsigned IW    = $clog2(DEPTH)
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     in_ready,
   input logic [IW:0]              occ,
   input logic [NPORT-1:0]         iss_valid,
   input logic [NPORT-1:0][IW-1:0] iss_id,
   input logic [RET-1:0]           ret_valid,
   input logic [RET-1:0][IW-1:0]   ret_id,
   input logic [DEPTH-1:0]         ent_valid,
   input logic [DEPTH-1:0]         ent_issued,
   input logic [DEPTH-1:0]         ent_done
);

   a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
      occ <= (IW + 1)'(DEPTH));

   a_r2_stall_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> occ <= $past(occ));

   for (genvar p = 0; p < NPORT; p++) begin : g_p
      a_r4_issue_fresh: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[p] |-> ent_valid[iss_id[p]] && !ent_issued[iss_id[p]]);

      a_r4_issue_marks: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[p] |=> ent_issued[$past(iss_id[p])]);

      for (genvar q = p + 1; q < NPORT; q++) begin : g_q
         a_r4_ports_distinct: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[p] && iss_valid[q] |-> iss_id[p] != iss_id[q]);
      end
   end

   for (genvar k = 0; k < RET; k++) begin : g_k
      a_r7_retire_done: assert property (@(posedge clk) disable iff (!rst_n)
         ret_valid[k] |-> ent_valid[ret_id[k]] && ent_done[ret_id[k]]);
      if (k > 0) begin : g_chain
         a_r7_retire_chain: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid[k] |-> ret_valid[k-1] && (ret_id[k] == ret_id[k-1] + IW'(1)));
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_e
      a_r6_done_after_issue: assert property (@(posedge clk) disable iff (!rst_n)
         ent_valid[e] && ent_done[e] |-> ent_issued[e]);
   end

endmodule

bind iw_sched iw_sched_chk #(.DEPTH(DEPTH), .NPORT(NPORT), .RET(RET)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .occ        (occ),
   .iss_valid  (iss_valid),
   .iss_id     (iss_id),
   .ret_valid  (ret_valid),
   .ret_id     (ret_id),
   .ent_valid  (ent_valid),
   .ent_issued (ent_issued),
   .ent_done   (ent_done)
);

// File: tb/iw_sched_test.sv
module iw_sched_test;

   localparam int DEPTH = 16;
   localparam int NPORT = 2;
   localparam int SLOTS = 3;
   localparam int RET   = 3;
   localparam int TW    = 4;
   localparam int IW    = 4;
   localparam int PW    = 1;

   logic                      clk = 1'b0;
   logic                      rst_n;
   logic [SLOTS-1:0]          in_valid;
   logic [SLOTS-1:0][TW-1:0]  in_dst, in_src_a, in_src_b;
   logic [SLOTS-1:0]          in_dst_en, in_src_a_en, in_src_b_en;
   logic [SLOTS-1:0][PW-1:0]  in_port;
   logic                      in_ready;
   logic [SLOTS-1:0][IW-1:0]  in_id;
   logic [NPORT-1:0]          iss_valid;
   logic [NPORT-1:0][IW-1:0]  iss_id;
   logic [NPORT-1:0]          cmp_valid;
   logic [NPORT-1:0][IW-1:0]  cmp_id;
   logic [RET-1:0]            ret_valid;
   logic [RET-1:0][IW-1:0]    ret_id;

   always #10 clk = ~clk;

   iw_sched #(.DEPTH(DEPTH), .NPORT(NPORT), .SLOTS(SLOTS), .RET(RET), .TW(TW)) uut (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_dst(in_dst), .in_dst_en(in_dst_en),
      .in_src_a(in_src_a), .in_src_a_en(in_src_a_en),
      .in_src_b(in_src_b), .in_src_b_en(in_src_b_en),
      .in_port(in_port), .in_ready(in_ready), .in_id(in_id),
      .iss_valid(iss_valid), .iss_id(iss_id),
      .cmp_valid(cmp_valid), .cmp_id(cmp_id),
      .ret_valid(ret_valid), .ret_id(ret_id)
   );

   // Reference queue model
   bit mv[DEPTH], mi[DEPTH], md[DEPTH];
   bit m_sa_en[DEPTH], m_sb_en[DEPTH], m_d_en[DEPTH];
   int m_sa[DEPTH], m_sb[DEPTH], m_d[DEPTH], m_prt[DEPTH];
   int m_seq[DEPTH], m_icyc[DEPTH], m_lat[DEPTH];
   int mhead = 0, mtail = 0, mcount = 0, seqctr = 0, rseq_next = 0, cyc = 0;
   bit last_ready = 1'b1;
   bit saw_stall = 1'b0;
   int nchk = 0, nfail = 0;
   bit [31:0] lfsr = 32'h1d2c_3b4a;

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   endtask

   function automatic bit [31:0] rnd();
      lfsr ^= lfsr << 13;
      lfsr ^= lfsr >> 17;
      lfsr ^= lfsr << 5;
      return lfsr;
   endfunction

   function automatic bit m_ready(input int e);
      if (!mv[e] || mi[e]) return 1'b0;
      for (int o = 0; o < DEPTH; o++) begin
         if (o != e && mv[o] && !md[o] && m_d_en[o] && m_seq[o] < m_seq[e] &&
             ((m_sa_en[e] && m_sa[e] == m_d[o]) || (m_sb_en[e] && m_sb[e] == m_d[o])))
            return 1'b0;
      end
      return 1'b1;
   endfunction

   // Sample after an edge: compare outputs with the model and advance it.
   task automatic tick();
      int  exp_id[NPORT];
      bit  exp_v[NPORT];
      bit  go;
      int  nret;
      @(posedge clk);
      #2;
      cyc++;
      last_ready = (DEPTH - mcount) >= SLOTS;
      if (!last_ready) saw_stall = 1'b1;
      check(in_ready == last_ready, "R2 in_ready", int'(in_ready), int'(last_ready));
      for (int p = 0; p < NPORT; p++) begin
         exp_v[p] = 1'b0; exp_id[p] = 0;
         for (int e = 0; e < DEPTH; e++) begin
            if (m_prt[e] == p && m_ready(e) && (!exp_v[p] || m_seq[e] < m_seq[exp_id[p]])) begin
               exp_v[p] = 1'b1; exp_id[p] = e;
            end
         end
         check(iss_valid[p] == exp_v[p], "R4 issue valid", int'(iss_valid[p]), int'(exp_v[p]));
         if (exp_v[p])
            check(int'(iss_id[p]) == exp_id[p], "R3 oldest ready id", int'(iss_id[p]), exp_id[p]);
      end
      for (int p = 0; p < NPORT; p++) begin
         if (exp_v[p]) begin mi[exp_id[p]] = 1'b1; m_icyc[exp_id[p]] = cyc; end
      end
      go = 1'b1; nret = 0;
      for (int k = 0; k < RET; k++) begin
         int  id;
         bit  ev;
         id = (mhead + k) % DEPTH;
         ev = go && mv[id] && md[id];
         go = ev;
         check(ret_valid[k] == ev, "R7 retire valid", int'(ret_valid[k]), int'(ev));
         if (ev) begin
            check(int'(ret_id[k]) == id, "R7 retire id", int'(ret_id[k]), id);
            check(m_seq[id] == rseq_next, "R7 retire order", m_seq[id], rseq_next);
            rseq_next++;
            nret++;
         end
      end
      for (int k = 0; k < nret; k++) mv[(mhead + k) % DEPTH] = 1'b0;
      mhead  = (mhead + nret) % DEPTH;
      mcount = mcount - nret;
   endtask

   // After inputs are driven: check indices and apply the coming edge to the model.
   task automatic commit();
      #1;
      if (last_ready) begin
         for (int s = 0; s < SLOTS; s++) begin
            if (in_valid[s]) begin
               check(int'(in_id[s]) == mtail, "R1 slot index", int'(in_id[s]), mtail);
               mv[mtail] = 1'b1; mi[mtail] = 1'b0; md[mtail] = 1'b0;
               m_d[mtail] = int'(in_dst[s]);     m_d_en[mtail]  = in_dst_en[s];
               m_sa[mtail] = int'(in_src_a[s]);  m_sa_en[mtail] = in_src_a_en[s];
               m_sb[mtail] = int'(in_src_b[s]);  m_sb_en[mtail] = in_src_b_en[s];
               m_prt[mtail] = int'(in_port[s]);
               m_seq[mtail] = seqctr;
               m_lat[mtail] = 1 + (seqctr % 4);
               seqctr++;
               mtail = (mtail + 1) % DEPTH;
               mcount++;
            end
         end
      end
      for (int c = 0; c < NPORT; c++) begin
         if (cmp_valid[c]) begin
            int id;
            id = int'(cmp_id[c]);
            if (mv[id] && mi[id] && m_icyc[id] < cyc) md[id] = 1'b1;
         end
      end
   endtask

   task automatic clear_inputs();
      in_valid = '0; in_dst = '0; in_dst_en = '0;
      in_src_a = '0; in_src_a_en = '0; in_src_b = '0; in_src_b_en = '0;
      in_port = '0; cmp_valid = '0; cmp_id = '0;
   endtask

   task automatic set_slot(input int s, input int dst, input bit de, input int sa, input bit sae,
                           input int sb, input bit sbe, input int prt);
      in_valid[s] = 1'b1;
      in_dst[s] = TW'(dst); in_dst_en[s] = de;
      in_src_a[s] = TW'(sa); in_src_a_en[s] = sae;
      in_src_b[s] = TW'(sb); in_src_b_en[s] = sbe;
      in_port[s] = PW'(prt);
   endtask

   task automatic rand_group(input bit en);
      for (int s = 0; s < SLOTS; s++) begin
         bit [31:0] r;
         r = rnd();
         in_valid[s]    = en && (r[1:0] != 2'b00);
         in_dst[s]      = TW'(r[7:4] % 6);
         in_dst_en[s]   = r[8] | r[9];
         in_src_a[s]    = TW'(r[15:12] % 6);
         in_src_a_en[s] = r[10];
         in_src_b[s]    = TW'(r[19:16] % 6);
         in_src_b_en[s] = r[11] & r[20];
         in_port[s]     = PW'(r[24]);
      end
   endtask

   task automatic pick_cmp(input bit allow);
      cmp_valid = '0; cmp_id = '0;
      for (int c = 0; c < NPORT; c++) begin
         if (allow) begin
            for (int e = 0; e < DEPTH; e++) begin
               if (!cmp_valid[c] && mv[e] && mi[e] && !md[e] && m_prt[e] == c &&
                   cyc >= m_icyc[e] + m_lat[e]) begin
                  cmp_valid[c] = 1'b1; cmp_id[c] = IW'(e);
               end
            end
         end else if (rnd() % 5 == 0) begin
            // stray pulse; the model decides whether it may count
            cmp_valid[c] = 1'b1; cmp_id[c] = IW'(rnd() % DEPTH);
         end
      end
   endtask

   initial begin
      #(20 * 150000);
      check(1'b0, "watchdog", cyc, 0);
      summary();
   end

   initial begin
      for (int e = 0; e < DEPTH; e++) begin
         mv[e] = 0; mi[e] = 0; md[e] = 0; m_prt[e] = 0; m_seq[e] = 0;
         m_icyc[e] = 0; m_lat[e] = 1;
      end
      clear_inputs();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #2;
      check(in_ready == 1'b1, "R8 reset ready", int'(in_ready), 1);
      check(iss_valid == '0, "R8 reset issue", int'(iss_valid), 0);
      check(ret_valid == '0, "R8 reset retire", int'(ret_valid), 0);
      rst_n = 1'b1;

      // Directed: RAW pair 0->1, WAW between 0 and 2 (different ports)
      set_slot(0, 1, 1, 0, 0, 0, 0, 0);
      set_slot(1, 2, 1, 1, 1, 0, 0, 1);
      set_slot(2, 1, 1, 3, 1, 0, 0, 1);
      commit();
      tick();
      check(iss_valid[0] && iss_id[0] == 0, "R5 issue right after alloc", int'(iss_id[0]), 0);
      check(iss_valid[1] && iss_id[1] == 2, "R9 WAW does not block", int'(iss_id[1]), 2);
      clear_inputs();
      cmp_valid[1] = 1'b1; cmp_id[1] = 1;    // entry 1 not issued: must be ignored
      commit();
      tick();
      check(iss_valid[1] == 1'b0, "R3 RAW blocks issue", int'(iss_valid[1]), 0);
      clear_inputs();
      cmp_valid = 2'b11; cmp_id[0] = 0; cmp_id[1] = 2;
      commit();
      tick();
      check(iss_valid[1] && iss_id[1] == 1, "R3 wake next cycle", int'(iss_id[1]), 1);
      check(ret_valid[0] && ret_id[0] == 0, "R7 oldest retires", int'(ret_id[0]), 0);
      check(ret_valid[1] == 1'b0, "R6 stray pulse ignored", int'(ret_valid[1]), 0);
      clear_inputs();
      commit();
      tick();
      cmp_valid[1] = 1'b1; cmp_id[1] = 1;
      commit();
      tick();
      check(ret_valid[0] && ret_id[0] == 1, "R7 lane0 in order", int'(ret_id[0]), 1);
      check(ret_valid[1] && ret_id[1] == 2, "R7 two lanes", int'(ret_id[1]), 2);
      check(ret_valid[2] == 1'b0, "R7 stop at empty", int'(ret_valid[2]), 0);
      clear_inputs();

      // Sweep: alternating free-flowing and held completion phases
      for (int i = 0; i < 4000; i++) begin
         rand_group(1'b1);
         pick_cmp(((i / 150) % 3) != 1);
         commit();
         tick();
      end
      check(saw_stall, "R2 full window reached", int'(saw_stall), 1);

      // Drain
      for (int i = 0; i < 300; i++) begin
         in_valid = '0;
         pick_cmp(1'b1);
         commit();
         tick();
      end
      check(rseq_next == seqctr, "R7 every entry retired", rseq_next, seqctr);
      check(in_ready == 1'b1, "R2 ready when empty", int'(in_ready), 1);
      summary();
   end

endmodule